// File: doc/BRIEF.md
# Shared Interrupt Pending and Vector Controller

This block gathers up to twenty-four timer and capture/compare interrupt sources onto one shared interrupt line. Every source has an event input. An event sets a latched pending bit in one of two banks: a 16-bit primary bank and an 8-bit secondary bank. Some bit positions in each bank are unused. Those positions never latch and always read back as zero.

A read-only vector register returns a number for the highest-priority source that is both pending and enabled. Reading the vector register clears the pending bit of the source it names. That read is the only way software can clear a pending bit. Writes to the pending banks are discarded. A combined request output is high while any enabled source is pending.

Top module: `shared_irq_vector_ctrl`

## Requirements
- R1: After reset both pending banks read zero, the vector reads zero and `irq_o` is low.
- R2: An event on a live source bit sets its pending bit from the next clock edge. The bit stays set until a vector read clears it.
- R3: The live positions are primary bits 0, 1 and 6 to 13 (mask 0x3FC3) and secondary bits 0 to 3 (mask 0x0F). All other positions never set, always read as zero and never win arbitration.
- R4: Priority is fixed. Every secondary bit ranks above every primary bit, and within a bank the lower index wins. The vector value is k+1 for secondary bit k, j+9 for primary bit j, and 0 when no source qualifies.
- R5: Only pending bits whose enable bit is set take part in arbitration. A pending bit whose enable is clear stays latched and reads back as pending.
- R6: A read strobe at address 2 returns the current vector. If the returned value is non-zero, exactly that source's pending bit is cleared at the next clock edge. A read that returns 0 clears nothing.
- R7: If an event arrives for a source in the same cycle as the vector read that would clear it, the event wins and the bit stays pending.
- R8: `irq_o` is high exactly when some live pending bit has its enable bit set.
- R9: Write strobes have no effect on any state. Reads of address 0 or 1 have no side effects.
- R10: The register map is as follows. Address 0 reads the primary bank, address 1 the secondary bank zero-extended, and address 2 the vector zero-extended. Address 3 reads zero. `bus_rdata_o` is zero whenever `bus_rd_i` is low. Read data is combinational in the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_evt_i | input | 16 | Primary bank event pulses, one per source |
| sec_evt_i | input | 8 | Secondary bank event pulses, one per source |
| pri_en_i | input | 16 | Primary bank enable mask |
| sec_en_i | input | 8 | Secondary bank enable mask |
| bus_addr_i | input | 2 | Register select |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe (ignored) |
| bus_wdata_i | input | 16 | Write data (ignored) |
| bus_rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known value outside reset. They also assume that one read strobe stands for exactly one software access. Under that assumption, a strobe held high for several cycles counts as several vector reads, each of which clears one bit.

The bench drives its inputs only after the falling edge and keeps them stable across the rising edge. It also sets the event bits on reserved positions freely, so that the assertions guarding those positions are exercised. Its random phase mixes vector reads, pending-bank reads and writes with arbitrary data, so that writes arrive while sources are pending and events coincide with the clears they would race.

// File: rtl/svc_pkg.sv
package svc_pkg;

    // Register select values decoded on the bus address
    typedef enum logic [1:0] {
        SEL_PRI  = 2'd0,
        SEL_SEC  = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/svc_pend_bank.sv
module svc_pend_bank #(
    parameter int          W    = 16,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);

    typedef struct packed {
        logic [W-1:0] pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // Clear first, then set, so a simultaneous event survives the clear
    always_comb begin
        st_d      = st_q;
        st_d.pend = ((st_q.pend & ~clr_i) | evt_i) & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~LIVE) == '0);  // R3

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & LIVE) |=> ((st_q.pend & $past(evt_i & LIVE)) == $past(evt_i & LIVE)));  // R7

    AST_HOLD_UNTIL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & $past(st_q.pend & ~clr_i)) == $past(st_q.pend & ~clr_i)));  // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend | evt_i)) == '0));  // R9

endmodule

// File: rtl/svc_prio_pick.sv
module svc_prio_pick #(
    parameter int N  = 24,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Scan from the top down so the lowest set index is the one left
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

    always_comb begin
        if (found_o) begin
            AST_PICK_IS_REQ: assert (req_i[idx_o]);  // R4
        end
        AST_PICK_FOUND: assert (found_o == (|req_i));  // R4
    end

endmodule

// File: rtl/shared_irq_vector_ctrl.sv
module shared_irq_vector_ctrl
    import svc_pkg::*;
#(
    parameter int               PRI_W    = 16,
    parameter int               SEC_W    = 8,
    parameter logic [PRI_W-1:0] PRI_LIVE = 16'h3FC3,
    parameter logic [SEC_W-1:0] SEC_LIVE = 8'h0F,
    parameter int               DW       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRI_W-1:0] pri_evt_i,
    input  logic [SEC_W-1:0] sec_evt_i,
    input  logic [PRI_W-1:0] pri_en_i,
    input  logic [SEC_W-1:0] sec_en_i,
    input  logic [1:0]       bus_addr_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    output logic             irq_o
);

    localparam int N  = PRI_W + SEC_W;
    localparam int IW = $clog2(N);
    localparam int VW = $clog2(N + 1);

    logic [PRI_W-1:0] pri_pend;
    logic [SEC_W-1:0] sec_pend;
    logic [N-1:0]     req;
    logic             found;
    logic [IW-1:0]    win_idx;
    logic [VW-1:0]    vec;
    logic             rd_vec;
    logic [N-1:0]     clr_all;
    reg_sel_e         sel;

    // Secondary bank occupies the low (higher priority) ranks
    always_comb begin
        req = {pri_pend & pri_en_i & PRI_LIVE, sec_pend & sec_en_i & SEC_LIVE};
    end

    svc_prio_pick #(.N(N)) u_pick (
        .req_i   (req),
        .found_o (found),
        .idx_o   (win_idx)
    );

    always_comb begin
        sel     = reg_sel_e'(bus_addr_i);
        vec     = found ? (VW'(win_idx) + VW'(1)) : '0;
        rd_vec  = bus_rd_i && (sel == SEL_VEC);
        clr_all = (rd_vec && found) ? (N'(1) << win_idx) : '0;
        irq_o   = |req;
    end

    svc_pend_bank #(.W(SEC_W), .LIVE(SEC_LIVE)) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (sec_evt_i),
        .clr_i  (clr_all[SEC_W-1:0]),
        .pend_o (sec_pend)
    );

    svc_pend_bank #(.W(PRI_W), .LIVE(PRI_LIVE)) u_pri (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (pri_evt_i),
        .clr_i  (clr_all[N-1:SEC_W]),
        .pend_o (pri_pend)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            unique case (sel)
                SEL_PRI:  bus_rdata_o = DW'(pri_pend);
                SEL_SEC:  bus_rdata_o = DW'(sec_pend);
                SEL_VEC:  bus_rdata_o = DW'(vec);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_all));  // R6

    AST_VEC_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && found) |=> (($past(clr_all) & {pri_pend, sec_pend} & ~$past({pri_evt_i, sec_evt_i})) == '0));  // R6

    AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (bus_rd_i && sel == SEL_VEC ? bus_rdata_o != '0 : vec != '0));  // R8

    AST_WR_CANNOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i |=> ((pri_pend & ~$past(pri_pend | pri_evt_i) & $past(bus_wdata_i[PRI_W-1:0])) == '0));  // R9

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |-> bus_rdata_o == '0);  // R10

endmodule

// File: tb/shared_irq_vector_ctrl_test.sv
module shared_irq_vector_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PRI_OK = 16'h3FC3;  // R3 live masks
    localparam logic [7:0]  SEC_OK = 8'h0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pri_evt = '0, pri_en = '0, wdata = '0;
    logic [7:0]  sec_evt = '0, sec_en = '0;
    logic [1:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [15:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_pri = '0;
    logic [7:0]  m_sec = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shared_irq_vector_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .pri_evt_i (pri_evt), .sec_evt_i (sec_evt),
        .pri_en_i (pri_en), .sec_en_i (sec_en),
        .bus_addr_i (addr), .bus_rd_i (rd), .bus_wr_i (wr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
    );

    function automatic int model_vec();
        for (int k = 0; k < 8; k++)
            if (m_sec[k] && sec_en[k] && SEC_OK[k]) return k + 1;
        for (int j = 0; j < 16; j++)
            if (m_pri[j] && pri_en[j] && PRI_OK[j]) return j + 9;
        return 0;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle after the falling edge, check before the rising edge, advance the model
    task automatic step(input logic [15:0] ep, input logic [7:0] es,
                        input logic [15:0] np, input logic [7:0] ns,
                        input logic [1:0] a, input logic r, input logic w,
                        input logic [15:0] wd, input string tag);
        int v;
        int exp_rd;
        pri_evt = ep; sec_evt = es; pri_en = np; sec_en = ns;
        addr = a; rd = r; wr = w; wdata = wd;
        #1;
        v = model_vec();
        chk({tag, " irq"}, int'(irq), int'(v != 0));
        exp_rd = 0;
        if (r) begin
            case (a)
                2'd0: exp_rd = int'(m_pri);
                2'd1: exp_rd = int'(m_sec);
                2'd2: exp_rd = v;
                default: exp_rd = 0;
            endcase
        end
        chk({tag, " rdata"}, int'(rdata), exp_rd);
        if (r && a == 2'd2 && v != 0) begin
            if (v <= 8) m_sec[v-1] = 1'b0;
            else        m_pri[v-9] = 1'b0;
        end
        m_pri = m_pri | (ep & PRI_OK);
        m_sec = m_sec | (es & SEC_OK);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [1:0] a, input string tag);
        step('0, '0, pri_en, sec_en, a, 1'b1, 1'b0, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, "R1 pri");
        rd_reg(2'd1, "R1 sec");
        rd_reg(2'd2, "R1 vec");

        // R2/R3/R5: all primary events, enables off
        step(16'hFFFF, '0, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R2 set");
        rd_reg(2'd0, "R3 pri reserved");
        rd_reg(2'd2, "R5 masked vec");
        chk("R5 latched", int'(m_pri), 16'h3FC3);

        // R9 writes ignored
        step('0, '0, '0, '0, 2'd0, 1'b0, 1'b1, 16'h0000, "R9 wr pri");
        step('0, '0, '0, '0, 2'd1, 1'b0, 1'b1, 16'hFFFF, "R9 wr sec");
        rd_reg(2'd0, "R9 pri");
        rd_reg(2'd1, "R9 sec");

        // R3 secondary reserved
        step('0, 8'hFF, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R3 sec set");
        rd_reg(2'd1, "R3 sec reserved");

        // R4/R6/R8 drain by vector reads
        pri_en = 16'hFFFF; sec_en = 8'hFF;
        for (int i = 0; i < 15; i++) rd_reg(2'd2, "R4 R6 drain");
        rd_reg(2'd0, "R6 pri empty");
        rd_reg(2'd1, "R6 sec empty");
        chk("R8 irq low", int'(irq), 0);

        // R7 set beats clear
        step(16'h0080, '0, 16'hFFFF, 8'hFF, 2'd0, 1'b0, 1'b0, '0, "R7 arm");
        step(16'h0080, '0, 16'hFFFF, 8'hFF, 2'd2, 1'b1, 1'b0, '0, "R7 race");
        rd_reg(2'd0, "R7 kept");
        rd_reg(2'd2, "R7 clear");

        // R8 reserved-only events never request
        step(16'hC03C, 8'hF0, 16'hFFFF, 8'hFF, 2'd0, 1'b0, 1'b0, '0, "R8 rsvd");
        step('0, '0, 16'hFFFF, 8'hFF, 2'd0, 1'b0, 1'b0, '0, "R8 rsvd idle");

        // R10 address 3 and idle bus
        step(16'h0001, '0, 16'hFFFF, 8'hFF, 2'd3, 1'b1, 1'b0, '0, "R10 addr3");
        step('0, '0, 16'hFFFF, 8'hFF, 2'd2, 1'b0, 1'b0, '0, "R10 idle");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ep;
            logic [7:0]  es;
            ep = ($urandom_range(0, 3) == 0) ? 16'($urandom) : '0;
            es = ($urandom_range(0, 3) == 0) ? 8'($urandom) : '0;
            step(ep, es, 16'($urandom), 8'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom), 16'($urandom), "R2 R4 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule